// File: doc/BRIEF.md
# PS/2 Mouse Wheel-Mode Unlock Detector

This block sits behind the receive deframer of a PS/2 pointing device. It watches the host-to-device byte stream and keeps track of which bytes are commands and which are argument bytes that follow a set-rate command. It holds the most recently programmed report rate. It also follows progress through a fixed run of three rate settings. When that run completes, the block raises a sticky flag that the rest of the device uses to switch to wheel-capable reporting.

The run is three set-rate commands in a row, with arguments of 200, then 100, then 80 reports per second. Any other command byte breaks the run. A wrong rate value also breaks it. A wrong value of 200 is treated as the first step of a fresh attempt. The flag stays set until the host sends a reset command or the block is reset synchronously. The set-defaults command only restarts the run.

Top module: `ps2_wheel_unlock`

## Requirements
- R1: During and after synchronous reset, `wheel_en` is 0 and `cur_rate` equals the `RESET_RATE` parameter (default 100, 0x64). No argument byte is expected.
- R2: A valid byte of 0xF3 that arrives while no argument is expected is a set-rate command. The next valid byte is its argument, whatever its value. An argument of 0xFF or 0xF3 is therefore never decoded as a command.
- R3: Every argument byte appears on `cur_rate` one clock after it is accepted, whether or not it advances the run. Command bytes and idle cycles leave `cur_rate` unchanged.
- R4: `wheel_en` rises one clock after the third argument of the run 0xF3,0xC8 / 0xF3,0x64 / 0xF3,0x50 (200, 100, 80) is accepted.
- R5: A command byte other than 0xF3 that arrives between the set-rate commands of a run restarts the run from its first step.
- R6: An argument that does not match the expected step restarts the run. If that argument equals 200 (0xC8), it counts as the first step of the new attempt.
- R7: Once set, `wheel_en` stays 1 through any bytes other than the reset command 0xFF. This includes argument 0xFF, other commands and further rate runs.
- R8: The command byte 0xFF clears `wheel_en` one clock after it is accepted, and it restarts the run.
- R9: The command byte 0xF6 restarts the run and leaves `wheel_en` unchanged.
- R10: If `rst` and `byte_vld` are both high in the same cycle, reset wins. The byte is dropped, and the following byte is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | One-cycle strobe marking a received host byte |
| byte_data | input | 8 | Received host byte, valid with `byte_vld` |
| wheel_en | output | 1 | Sticky wheel-mode enable flag |
| cur_rate | output | 8 | Most recently programmed report rate |

## Verification
The final 80 argument both loads the rate register and completes the run, so the bench checks in that one cycle that `cur_rate` reads 0x50 and that `wheel_en` rises together with it. A mismatching 200 also does two things in one cycle: it aborts the current run and starts a new one. The bench provokes this by sending 200, 200, 100, 80 and expects the unlock. A further collision is reset arriving together with a set-rate byte. The bench drives both in one cycle and then checks that the next byte is treated as a command and leaves the rate untouched.

// File: rtl/ps2wu_pkg.sv
package ps2wu_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_STEPS = 3;
  localparam int STEP_W  = $clog2(N_STEPS);

  localparam logic [BYTE_W-1:0] CMD_SET_RATE = 8'hF3;
  localparam logic [BYTE_W-1:0] CMD_RESET    = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_DEFAULTS = 8'hF6;

  localparam logic [BYTE_W-1:0] RATE_FIRST  = 8'd200;
  localparam logic [BYTE_W-1:0] RATE_SECOND = 8'd100;
  localparam logic [BYTE_W-1:0] RATE_THIRD  = 8'd80;

  typedef logic [STEP_W-1:0] step_t;

  // Expected rate argument for a given position in the unlock run
  function automatic logic [BYTE_W-1:0] step_rate(input int idx);
    case (idx)
      0:       return RATE_FIRST;
      1:       return RATE_SECOND;
      default: return RATE_THIRD;
    endcase
  endfunction

  // Position after a failed comparison: a first-step value begins a new try
  function automatic step_t step_after_miss(input logic [BYTE_W-1:0] v);
    return (v == step_rate(0)) ? step_t'(1) : step_t'(0);
  endfunction

  function automatic logic is_last_step(input step_t s);
    return s == step_t'(N_STEPS - 1);
  endfunction
endpackage

// File: rtl/ps2wu_cmd_decode.sv
module ps2wu_cmd_decode
  import ps2wu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              ev_arg,
  output logic              ev_restart,
  output logic              ev_clear
);
  logic arg_pending;
  logic is_cmd;
  logic ev_setrate;
  logic ev_defaults;

  assign is_cmd      = byte_vld && !arg_pending;
  assign ev_setrate  = is_cmd && (byte_data == CMD_SET_RATE);
  assign ev_arg      = byte_vld && arg_pending;
  assign ev_restart  = is_cmd && (byte_data != CMD_SET_RATE);
  assign ev_clear    = is_cmd && (byte_data == CMD_RESET);
  assign ev_defaults = is_cmd && (byte_data == CMD_DEFAULTS);

  always_ff @(posedge clk) begin
    if (rst)
      arg_pending <= 1'b0;
    else if (byte_vld)
      arg_pending <= ev_setrate;
  end

  // R2: the byte after a set-rate command is taken as its argument
  p_arg_follows_r2: assert property (@(posedge clk) disable iff (rst)
    ev_setrate |=> arg_pending);

  // R2: one argument only, then back to command decoding
  p_arg_once_r2: assert property (@(posedge clk) disable iff (rst)
    ev_arg |=> !arg_pending);

  p_event_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_arg, ev_setrate, ev_restart}));

  // R9: set-defaults is a restart and never a flag clear
  p_defaults_restart_r9: assert property (@(posedge clk) disable iff (rst)
    ev_defaults |-> (ev_restart && !ev_clear));
endmodule

// File: rtl/ps2wu_seq_match.sv
module ps2wu_seq_match
  import ps2wu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_arg,
  input  logic              ev_restart,
  input  logic [BYTE_W-1:0] arg_byte,
  output logic              unlock_ev
);
  step_t               step_q;
  step_t               step_d;
  logic [N_STEPS-1:0]  hit_vec;
  logic                hit_any;
  logic                miss_restart;

  for (genvar gi = 0; gi < N_STEPS; gi++) begin : g_hit
    assign hit_vec[gi] = (step_q == step_t'(gi)) && (arg_byte == step_rate(gi));
  end

  assign hit_any      = |hit_vec;
  assign unlock_ev    = ev_arg && hit_any && is_last_step(step_q);
  assign miss_restart = ev_arg && !hit_any;

  always_comb begin
    step_d = step_q;
    if (ev_arg) begin
      if (!hit_any)
        step_d = step_after_miss(arg_byte);
      else if (is_last_step(step_q))
        step_d = step_t'(0);
      else
        step_d = step_q + step_t'(1);
    end else if (ev_restart) begin
      step_d = step_t'(0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      step_q <= step_t'(0);
    else
      step_q <= step_d;
  end

  p_step_range_r4: assert property (@(posedge clk) disable iff (rst)
    step_q <= step_t'(N_STEPS - 1));

  // R5: any command other than set-rate sends the run back to the start
  p_cmd_restart_r5: assert property (@(posedge clk) disable iff (rst)
    ev_restart |=> (step_q == step_t'(0)));

  // R6: a mismatching first-step value begins a new attempt
  p_miss_first_r6: assert property (@(posedge clk) disable iff (rst)
    (miss_restart && arg_byte == RATE_FIRST) |=> (step_q == step_t'(1)));

  p_miss_other_r6: assert property (@(posedge clk) disable iff (rst)
    (miss_restart && arg_byte != RATE_FIRST) |=> (step_q == step_t'(0)));

  // R4: progress only through matching arguments
  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_arg && hit_any && !is_last_step(step_q)) |=> (step_q == $past(step_q) + step_t'(1)));
endmodule

// File: rtl/ps2wu_state_regs.sv
module ps2wu_state_regs
  import ps2wu_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_RATE = 8'd100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_ld,
  input  logic [BYTE_W-1:0] rate_in,
  input  logic              set_flag,
  input  logic              clr_flag,
  output logic              wheel_en,
  output logic [BYTE_W-1:0] cur_rate
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wheel_en <= 1'b0;
      cur_rate <= RESET_RATE;
    end else begin
      if (rate_ld)
        cur_rate <= rate_in;
      if (clr_flag)
        wheel_en <= 1'b0;
      else if (set_flag)
        wheel_en <= 1'b1;
    end
  end

  // R3: argument lands on the rate output one clock later
  p_rate_load_r3: assert property (@(posedge clk) disable iff (rst)
    rate_ld |=> (cur_rate == $past(rate_in)));

  p_rate_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rate_ld |=> $stable(cur_rate));

  // R4: the flag only rises after a completed run
  p_flag_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wheel_en) |-> $past(set_flag));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    set_flag |=> wheel_en);

  // R7: sticky until the reset command
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (wheel_en && !clr_flag) |=> wheel_en);

  // R8: reset command clears the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr_flag |=> !wheel_en);
endmodule

// File: rtl/ps2_wheel_unlock.sv
module ps2_wheel_unlock
  import ps2wu_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_RATE = 8'd100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              wheel_en,
  output logic [BYTE_W-1:0] cur_rate
);
  logic ev_arg;
  logic ev_restart;
  logic ev_clear;
  logic unlock_ev;

  ps2wu_cmd_decode u_decode (
    .clk        (clk),
    .rst        (rst),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .ev_arg     (ev_arg),
    .ev_restart (ev_restart),
    .ev_clear   (ev_clear)
  );

  ps2wu_seq_match u_match (
    .clk        (clk),
    .rst        (rst),
    .ev_arg     (ev_arg),
    .ev_restart (ev_restart),
    .arg_byte   (byte_data),
    .unlock_ev  (unlock_ev)
  );

  ps2wu_state_regs #(.RESET_RATE(RESET_RATE)) u_state (
    .clk      (clk),
    .rst      (rst),
    .rate_ld  (ev_arg),
    .rate_in  (byte_data),
    .set_flag (unlock_ev),
    .clr_flag (ev_clear),
    .wheel_en (wheel_en),
    .cur_rate (cur_rate)
  );

  // R10 / R1: reset leaves the outputs at their initial values
  always_ff @(posedge clk) begin
    if (!rst && $past(rst)) begin
      p_reset_state_r1: assert (!wheel_en && cur_rate == RESET_RATE);
    end
  end
endmodule

// File: tb/ps2_wheel_unlock_tb_top.sv
module ps2_wheel_unlock_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       wheel_en;
  logic [7:0] cur_rate;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    logic       flag;
    logic [7:0] rate;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  // independent reference model
  logic [7:0] run_vals [3] = '{8'd200, 8'd100, 8'd80};
  int         m_pos = 0;
  bit         m_arg = 0;
  bit         m_flag = 0;
  logic [7:0] m_rate = 8'd100;

  always #10 clk = ~clk;

  ps2_wheel_unlock dut_i (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .wheel_en  (wheel_en),
    .cur_rate  (cur_rate)
  );

  task automatic model_reset();
    m_pos = 0; m_arg = 0; m_flag = 0; m_rate = 8'd100;
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (m_arg) begin
      m_arg  = 0;
      m_rate = b;
      if (b == run_vals[m_pos]) begin
        if (m_pos == 2) begin m_flag = 1; m_pos = 0; end
        else m_pos = m_pos + 1;
      end else begin
        m_pos = (b == run_vals[0]) ? 1 : 0;
      end
    end else if (b == 8'hF3) begin
      m_arg = 1;
    end else begin
      m_pos = 0;
      if (b == 8'hFF) m_flag = 0;
    end
  endtask

  task automatic check(input logic f, input logic [7:0] r, input string tag);
    n_checks++;
    if (wheel_en !== f || cur_rate !== r) begin
      n_errors++;
      $display("FAIL %s: wheel_en=%0b cur_rate=%0d, expected wheel_en=%0b cur_rate=%0d",
               tag, wheel_en, cur_rate, f, r);
    end
  endtask

  // driver: one byte, expectation pushed after the capturing edge
  task automatic send(input logic [7:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
    @(posedge clk);
    #1 byte_vld = 1'b0;
    model_byte(b);
    e.flag = m_flag; e.rate = m_rate; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic send_rate(input logic [7:0] v, input string tag);
    send(8'hF3, tag);
    send(v, tag);
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  // monitor: compares one expectation per byte at the following falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.flag, e.rate, e.tag);
    end
  end

  initial begin
    #4_000_000;
    n_errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 8'd100, "R1 reset state");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, 8'd100, "R1 after reset release");

    // R3: rate loads even when it does not advance the run
    send_rate(8'd40, "R3 plain rate load");
    send(8'hE8, "R3 command leaves rate");
    drain();
    check(1'b0, 8'd40, "R3 idle holds rate");

    // R4: clean unlock; last argument loads rate and flag together
    send_rate(8'd200, "R4 step one");
    send_rate(8'd100, "R4 step two");
    send_rate(8'd80,  "R4 step three unlock");
    drain();

    // R7: sticky through other bytes; R2: 0xFF as argument is not a reset
    send(8'hE6, "R7 other command keeps flag");
    send_rate(8'hFF, "R2 argument 0xFF is data");
    send_rate(8'hF3, "R2 argument 0xF3 is data");
    send(8'hF6, "R9 defaults keeps flag");
    drain();

    // R8: reset command clears
    send(8'hFF, "R8 reset command clears");
    drain();

    // R5: interrupted run does not unlock
    send_rate(8'd200, "R5 step one");
    send(8'hE8, "R5 interrupting command");
    send_rate(8'd100, "R5 step two after break");
    send_rate(8'd80,  "R5 no unlock");
    drain();

    // R9: defaults in the middle restarts
    send_rate(8'd200, "R9 step one");
    send_rate(8'd100, "R9 step two");
    send(8'hF6, "R9 defaults restarts");
    send_rate(8'd80,  "R9 no unlock");
    drain();

    // R6: wrong value restarts
    send_rate(8'd200, "R6 step one");
    send_rate(8'd60,  "R6 wrong value");
    send_rate(8'd100, "R6 no progress");
    send_rate(8'd80,  "R6 no unlock");
    drain();

    // R6: a repeated 200 begins a new attempt
    send_rate(8'd200, "R6 first 200");
    send_rate(8'd200, "R6 second 200 restarts as step one");
    send_rate(8'd100, "R6 step two");
    send_rate(8'd80,  "R6 unlock after restart");
    drain();

    // R6: 200 as a late mismatch at the third step
    send(8'hFF, "R8 clear before late mismatch");
    send_rate(8'd200, "R6 late step one");
    send_rate(8'd100, "R6 late step two");
    send_rate(8'd200, "R6 late mismatch 200");
    send_rate(8'd100, "R6 late continue");
    send_rate(8'd80,  "R6 late unlock");
    drain();

    // R10: reset collides with a set-rate byte
    @(negedge clk);
    rst = 1'b1; byte_vld = 1'b1; byte_data = 8'hF3;
    @(negedge clk);
    rst = 1'b0; byte_vld = 1'b0;
    model_reset();
    check(1'b0, 8'd100, "R10 reset wins over byte");
    send(8'd50, "R10 next byte is a command");
    drain();
    check(1'b0, 8'd100, "R10 rate untouched");

    drain();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule